// File: doc/BRIEF.md
# Serially Programmed Nibble Register Bank

This block holds a bank of 4-bit configuration registers that are loaded over one asynchronous serial line in 8N1 format. While the data/control select input is low, every correctly framed character is split into a data nibble and an address nibble. The data goes to the register that the address selects. When echo is enabled, the same character is then sent back out on the serial output. A bank-select bit extends the 4-bit serial address to reach 31 registers. A divisor register sets the bit timing of both directions.

Register 15 is the configuration register, and it is reachable from either bank. Its bit 0 selects the upper bank and its bit 1 enables echo. Register 14 of the lower bank holds the baud divisor `d`. One bit lasts 16·(d+1) clock cycles. The receiver works from a 16x oversampling tick and samples each bit at its middle. The transmitter counts bits on the same tick. A new divisor takes effect only after the character that carried it has been echoed. With echo off, it takes effect at once. Characters that arrive while an echo is still going out are written at once, and their echoes wait in a one-entry queue.

Top module: `nibreg_bank`

## Requirements
- R1: Within a character, the first four bits after the start bit (LSB first) are the data nibble and the next four bits are the address nibble. The data is written to the register the address selects.
- R2: A character whose stop bit is sampled while `dcSel` is high writes nothing and is not echoed.
- R3: With bank bit 0, address a (0..14) selects register a. With bank bit 1, address a (0..14) selects register 16+a. Register i appears on `regsOut[4*i+3:4*i]`.
- R4: Address 15 always selects the shared register 15, whatever the bank bit. Its bit 0 is the bank bit and its bit 1 is echo enable.
- R5: A written character is sent back on `txd` as 8N1 (the same 8 bits, LSB first) when the echo-enable value after the write is 1. Otherwise `txd` stays high.
- R6: Register 14 of the lower bank holds the divisor d. Both the receiver and the transmitter use a bit time of 16·(d+1) clocks. Register 30 (upper bank, address 14) has no effect on timing.
- R7: When the divisor is written with echo on, the echo goes out at the old rate and the new rate applies after the echo. With echo off, the new rate applies to the next character.
- R8: Reset (`rstN` low while `pwrdnN` high) clears all registers except these two: register 15 becomes 4'b0010 (echo on, bank 0) and register 14 becomes 4'hF. The divisor in use returns to 15 and `txd` is high.
- R9: While `pwrdnN` is low, `rstN` low has no effect on any register.
- R10: A character whose stop bit samples low is discarded: nothing is written and nothing is echoed.
- R11: Characters sent back to back are all written. Their echoes are sent in arrival order, with at most one echo waiting behind the one being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset, honoured only while `pwrdnN` is high |
| pwrdnN | input | 1 | Active-low power-down; blocks reset while low |
| rxd | input | 1 | Serial input, idle high |
| dcSel | input | 1 | Data/control select; control characters are accepted while low |
| txd | output | 1 | Serial echo output, idle high |
| regsOut | output | 124 | All 31 registers, register i on bits 4i+3..4i |

## Verification
The bench writes every address of both banks in back-to-back bursts, with data nibbles computed from the address. This tells a correct field split and bank decode apart from swapped nibbles, a wrong bank offset, or a lost echo in the queue. It also writes address 14 in the upper bank and address 15 with the bank bit set, to separate the divisor register and the shared register from their upper-bank neighbours. It changes the divisor once with echo on and once with echo off, then decodes the echo and the next character at the rate each case should use, so a deferral applied too early or too late shows up as a corrupt byte. Characters sent with the select input high, characters with a low stop bit, and reset pulses taken with power-down low and with power-down high must each leave the register image and the echo stream exactly as the bench model predicts.

// File: rtl/nibreg_pkg.sv
package nibreg_pkg;
  localparam int NIB_W  = 4;
  localparam int ADDR_W = 4;
  localparam int CHAR_W = NIB_W + ADDR_W;
  localparam int NREG   = 2 * (2 ** ADDR_W) - 1;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] addr;
    logic [NIB_W-1:0]  data;
    logic              txDone;
    logic              txFree;
  } ctrlStrb_t;
endpackage

// File: rtl/nibreg_ctrl.sv
module nibreg_ctrl
  import nibreg_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              doReset,
  input  logic              rxd,
  input  logic              dcSel,
  input  logic [NIB_W-1:0]  activeDiv,
  input  logic              txGo,
  input  logic [CHAR_W-1:0] txByte,
  output ctrlStrb_t         strb,
  output logic              txd
);
  localparam int SUB_W = $clog2(OVS);
  localparam int IDX_W = $clog2(CHAR_W + 2);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_STOP = IDX_W'(CHAR_W + 1);

  logic [1:0] rxSync, dcSync;
  logic rxS, dcS;
  always_ff @(posedge clk) begin
    if (doReset) begin
      rxSync <= 2'b11;
      dcSync <= 2'b11;
    end else begin
      rxSync <= {rxSync[0], rxd};
      dcSync <= {dcSync[0], dcSel};
    end
  end
  assign rxS = rxSync[1];
  assign dcS = dcSync[1];

  // oversampling tick, period activeDiv+1 clocks
  logic [NIB_W-1:0] divCnt;
  logic tick;
  assign tick = (divCnt == '0);
  always_ff @(posedge clk) begin
    if (doReset) divCnt <= '0;
    else         divCnt <= tick ? activeDiv : divCnt - 1'b1;
  end

  // receiver
  logic              rxAct, rxPrev;
  logic [SUB_W-1:0]  rxSub;
  logic [IDX_W-1:0]  rxIdx;
  logic [CHAR_W-1:0] rxShift;
  logic              rxSample;
  assign rxSample = tick && rxAct && (rxSub == SUB_MID);

  always_ff @(posedge clk) begin
    if (doReset) begin
      rxAct   <= 1'b0;
      rxPrev  <= 1'b1;
      rxSub   <= '0;
      rxIdx   <= '0;
      rxShift <= '0;
    end else if (tick) begin
      rxPrev <= rxS;
      if (!rxAct) begin
        if (rxPrev && !rxS) begin
          rxAct <= 1'b1;
          rxSub <= '0;
          rxIdx <= '0;
        end
      end else begin
        rxSub <= rxSub + 1'b1;
        if (rxSub == SUB_MID) begin
          rxIdx <= rxIdx + 1'b1;
          if (rxIdx == '0) begin
            if (rxS) rxAct <= 1'b0;
          end else if (rxIdx == IDX_STOP) begin
            rxAct <= 1'b0;
          end else begin
            rxShift <= {rxS, rxShift[CHAR_W-1:1]};
          end
        end
      end
    end
  end

  // transmitter
  logic              txBusy;
  logic [SUB_W-1:0]  txSub;
  logic [IDX_W-1:0]  txIdx;
  logic [CHAR_W+1:0] txShift;
  logic              txFin;
  assign txFin = txBusy && tick && (txSub == SUB_LAST) && (txIdx == IDX_STOP);

  always_ff @(posedge clk) begin
    if (doReset) begin
      txBusy  <= 1'b0;
      txSub   <= '0;
      txIdx   <= '0;
      txShift <= '1;
    end else if (txGo && (!txBusy || txFin)) begin
      txBusy  <= 1'b1;
      txSub   <= '0;
      txIdx   <= '0;
      txShift <= {1'b1, txByte, 1'b0};
    end else if (txFin) begin
      txBusy <= 1'b0;
    end else if (txBusy && tick) begin
      txSub <= txSub + 1'b1;
      if (txSub == SUB_LAST) begin
        txShift <= {1'b1, txShift[CHAR_W+1:1]};
        txIdx   <= txIdx + 1'b1;
      end
    end
  end
  assign txd = txShift[0];

  assign strb.wrEn   = rxSample && (rxIdx == IDX_STOP) && rxS && !dcS;
  assign strb.addr   = rxShift[CHAR_W-1:NIB_W];
  assign strb.data   = rxShift[NIB_W-1:0];
  assign strb.txDone = txFin;
  assign strb.txFree = !txBusy || txFin;

  // R5
  stop_high_chk: assert property (@(posedge clk) disable iff (doReset)
    (txBusy && txIdx == IDX_STOP) |-> txd);
  // R11
  go_when_free_chk: assert property (@(posedge clk) disable iff (doReset)
    (txGo && txBusy && !txFin) |=> $stable(txShift) || (txBusy && tick));
endmodule

// File: rtl/nibreg_dp.sv
module nibreg_dp
  import nibreg_pkg::*;
(
  input  logic                  clk,
  input  logic                  doReset,
  input  ctrlStrb_t             strb,
  output logic [NREG*NIB_W-1:0] regsOut,
  output logic [NIB_W-1:0]      activeDiv,
  output logic                  txGo,
  output logic [CHAR_W-1:0]     txByte
);
  localparam int CFG_I  = 2 ** ADDR_W - 1;
  localparam int BAUD_I = 2 ** ADDR_W - 2;
  localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_I);
  localparam logic [ADDR_W:0]   CFG_W  = (ADDR_W+1)'(CFG_I);
  localparam logic [ADDR_W:0]   BAUD_W = (ADDR_W+1)'(BAUD_I);
  localparam logic [NIB_W-1:0]  CFG_RST  = NIB_W'(2);
  localparam logic [NIB_W-1:0]  BAUD_RST = '1;

  function automatic logic [NIB_W-1:0] rstVal(int idx);
    if (idx == CFG_I)  return CFG_RST;
    if (idx == BAUD_I) return BAUD_RST;
    return '0;
  endfunction

  logic [NIB_W-1:0] regs [NREG];
  logic shadow, echoEn, newEcho, wrEcho, isBaud, launch, goBaud;
  logic [ADDR_W:0] wrIdx;
  logic [CHAR_W-1:0] rawByte, pendByte;
  logic pendValid, pendBaud, inFlightBaud;

  assign shadow  = regs[CFG_I][0];
  assign echoEn  = regs[CFG_I][1];
  assign wrIdx   = (strb.addr == CFG_A) ? CFG_W : {shadow, strb.addr};
  assign newEcho = (strb.addr == CFG_A) ? strb.data[1] : echoEn;
  assign wrEcho  = strb.wrEn && newEcho;
  assign isBaud  = strb.wrEn && (wrIdx == BAUD_W);
  assign rawByte = {strb.addr, strb.data};

  assign txGo   = pendValid || wrEcho;
  assign txByte = pendValid ? pendByte : rawByte;
  assign goBaud = pendValid ? pendBaud : isBaud;
  assign launch = txGo && strb.txFree;

  always_ff @(posedge clk) begin
    if (doReset) begin
      for (int i = 0; i < NREG; i++) regs[i] <= rstVal(i);
    end else if (strb.wrEn) begin
      regs[wrIdx] <= strb.data;
    end
  end

  always_ff @(posedge clk) begin
    if (doReset) begin
      pendValid    <= 1'b0;
      pendBaud     <= 1'b0;
      pendByte     <= '0;
      inFlightBaud <= 1'b0;
      activeDiv    <= BAUD_RST;
    end else begin
      if (launch) begin
        pendValid <= pendValid && wrEcho;
        if (pendValid && wrEcho) begin
          pendByte <= rawByte;
          pendBaud <= isBaud;
        end
      end else if (wrEcho) begin
        pendValid <= 1'b1;
        pendByte  <= rawByte;
        pendBaud  <= isBaud;
      end

      if (launch)           inFlightBaud <= goBaud;
      else if (strb.txDone) inFlightBaud <= 1'b0;

      if (isBaud && !newEcho)                  activeDiv <= strb.data;
      else if (strb.txDone && inFlightBaud)    activeDiv <= regs[BAUD_I];
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regsOut[g*NIB_W +: NIB_W] = regs[g];
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (doReset)
    (pendValid && wrEcho) |-> strb.txFree);
  // R7
  div_hold_chk: assert property (@(posedge clk) disable iff (doReset)
    (inFlightBaud && !strb.txDone && !strb.wrEn) |=> $stable(activeDiv));
endmodule

// File: rtl/nibreg_bank.sv
module nibreg_bank
  import nibreg_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pwrdnN,
  input  logic                  rxd,
  input  logic                  dcSel,
  output logic                  txd,
  output logic [NREG*NIB_W-1:0] regsOut
);
  logic doReset;
  ctrlStrb_t strb;
  logic [NIB_W-1:0] activeDiv;
  logic txGo;
  logic [CHAR_W-1:0] txByte;

  assign doReset = !rstN && pwrdnN;

  nibreg_ctrl #(.OVS(OVS)) u_ctrl (
    .clk(clk), .doReset(doReset), .rxd(rxd), .dcSel(dcSel),
    .activeDiv(activeDiv), .txGo(txGo), .txByte(txByte),
    .strb(strb), .txd(txd)
  );

  nibreg_dp u_dp (
    .clk(clk), .doReset(doReset), .strb(strb), .regsOut(regsOut),
    .activeDiv(activeDiv), .txGo(txGo), .txByte(txByte)
  );
endmodule

// File: tb/nibreg_bank_test.sv
`timescale 1ns/1ps
module nibreg_bank_test;
  localparam int NR = 31;

  logic clk = 1'b0;
  logic rstN = 1'b0, pwrdnN = 1'b1, rxd = 1'b1, dcSel = 1'b0;
  logic txd;
  logic [NR*4-1:0] regsOut;

  nibreg_bank uut (.clk(clk), .rstN(rstN), .pwrdnN(pwrdnN), .rxd(rxd),
                   .dcSel(dcSel), .txd(txd), .regsOut(regsOut));

  always #4 clk = ~clk;

  int nChecks = 0, nFails = 0;
  int expDiv = 15;
  logic [3:0] model [NR];
  logic [7:0] echoBuf [64];
  logic [7:0] expEcho [64];
  int echoCnt = 0, expCnt = 0, echoBad = 0, seen = 0;
  logic monOn = 1'b0;

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < NR; i++) model[i] = 4'h0;
    model[15] = 4'b0010;
    model[14] = 4'hF;
  endtask

  task automatic chkRegs(string req);
    for (int i = 0; i < NR; i++) chk(req, int'(regsOut[4*i +: 4]), int'(model[i]));
  endtask

  task automatic sendChar(logic [7:0] b, logic stopBit);
    int bp = 16 * (expDiv + 1);
    rxd = 1'b0;
    repeat (bp) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (bp) @(negedge clk);
    end
    rxd = stopBit;
    repeat (bp) @(negedge clk);
    rxd = 1'b1;
    if (!stopBit) repeat (2 * bp) @(negedge clk);
  endtask

  // write through the serial line and update the bench model (R1, R3, R4, R5)
  task automatic wr(int a, int d);
    logic echo;
    int idx;
    echo = (a == 15) ? d[1] : model[15][1];
    idx  = (a == 15) ? 15 : (model[15][0] ? 16 + a : a);
    sendChar({a[3:0], d[3:0]}, 1'b1);
    model[idx] = d[3:0];
    if (echo && expCnt < 64) begin
      expEcho[expCnt] = {a[3:0], d[3:0]};
      expCnt++;
    end
  endtask

  task automatic settle(int bits);
    repeat (bits * 16 * (expDiv + 1)) @(negedge clk);
  endtask

  task automatic chkEchoes(string req);
    chk(req, echoCnt, expCnt);
    chk(req, echoBad, 0);
    for (int i = seen; i < expCnt && i < echoCnt; i++)
      chk(req, int'(echoBuf[i]), int'(expEcho[i]));
    seen = expCnt;
  endtask

  // echo decoder at the rate the bench expects
  initial begin
    wait (monOn);
    forever begin
      int bp;
      logic [7:0] b;
      @(negedge txd);
      bp = 16 * (expDiv + 1);
      repeat (bp / 2) @(negedge clk);
      if (txd !== 1'b0) echoBad++;
      for (int i = 0; i < 8; i++) begin
        repeat (bp) @(negedge clk);
        b[i] = txd;
      end
      repeat (bp) @(negedge clk);
      if (txd !== 1'b1) echoBad++;
      if (echoCnt < 64) echoBuf[echoCnt] = b;
      echoCnt++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    modelReset();
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R8 reset state
    chkRegs("R8");
    chk("R8", int'(txd), 1);
    monOn = 1'b1;

    // R7 divisor change with echo on: echo at old rate, then new rate
    wr(14, 1);
    settle(12);
    chkEchoes("R7");
    expDiv = 1;
    wr(0, 5);
    settle(12);
    chkEchoes("R6");
    chkRegs("R6");

    // R1 R3 R11 lower bank burst, back to back
    for (int a = 0; a < 14; a++) wr(a, (a * 7 + 3) & 15);
    settle(12);
    chkRegs("R3");
    chkEchoes("R11");

    // R4 R3 upper bank burst, incl. address 14 (no timing effect, R6)
    wr(15, 3);
    for (int a = 0; a < 15; a++) wr(a, (a * 5 + 1) & 15);
    settle(12);
    chkRegs("R3");
    chkEchoes("R6");
    wr(15, 2);
    settle(12);
    chkRegs("R4");
    chkEchoes("R4");

    // R2 select high: ignored
    dcSel = 1'b1;
    sendChar(8'h39, 1'b1);
    dcSel = 1'b0;
    settle(12);
    chkRegs("R2");
    chkEchoes("R2");

    // R10 framing error
    sendChar(8'h26, 1'b0);
    settle(12);
    chkRegs("R10");
    chkEchoes("R10");

    // R5 echo disabled
    wr(15, 0);
    wr(1, 10);
    settle(12);
    chkRegs("R5");
    chkEchoes("R5");

    // R7 divisor change with echo off takes effect at once
    wr(14, 3);
    expDiv = 3;
    wr(2, 12);
    wr(15, 2);
    settle(12);
    chkRegs("R7");
    chkEchoes("R7");

    // R9 reset blocked by power-down
    pwrdnN = 1'b0;
    rstN = 1'b0;
    repeat (20) @(negedge clk);
    rstN = 1'b1;
    pwrdnN = 1'b1;
    repeat (4) @(negedge clk);
    chkRegs("R9");

    // R8 reset with power-down high, then echo at the reset rate
    rstN = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    modelReset();
    expDiv = 15;
    repeat (4) @(negedge clk);
    chkRegs("R8");
    chk("R8", int'(txd), 1);
    wr(3, 6);
    settle(12);
    chkRegs("R8");
    chkEchoes("R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule